// File: doc/BRIEF.md
# Serial Key Matrix Scanner

This block scans an 8 by 8 key matrix that sits behind two external shift registers. Both registers share one shift clock. One of them is a serial-in, parallel-out register with a strobe, and its outputs drive the matrix lines. The other is a parallel-in, serial-out register that captures the sense lines. The strobe line selects the phase. While it is high, drive bits are shifted into the drive register. When it falls, the drive outputs latch and the sense register takes its parallel snapshot, which is then clocked out bit by bit.

The scanner sits idle, with every output low, until an external any-key detect input reports that some key is down. It then makes nine passes. In each of the first eight passes a single drive line is active and the matching sense byte is read back. The ninth pass shifts in all zeros, so the matrix is left undriven. A key is reported as a 6-bit code with a one-cycle valid pulse, and only after two successive scans agree on it. The shift clock rate comes from a divider input.

Top module: `kms_scanner`

## Requirements
- R1: While no scan is running, `ser_clk_o`, `strobe_o` and `ser_dat_o` stay low and no shift clock edge occurs.
- R2: When `wake_i` is high in the idle state, a scan starts on the next clock edge, and `strobe_o` is high in the following cycle.
- R3: In pass p (p = 0..7) with `strobe_o` high, eight data bits are sent, each followed by one rising edge of `ser_clk_o`. The bit for drive line 7 goes first and line 0 goes last, so that after eight edges line r's bit (the drive register shifts toward line 7) sits on output r. Only line p's bit is 1.
- R4: After the write phase, `strobe_o` falls to capture the sense lines. Then `ser_dat_i` is sampled eight times, each sample taken while `ser_clk_o` is low and followed by one rising edge. The first sample is sense column 7 and the last is column 0. `ser_dat_o` is low whenever `strobe_o` is low.
- R5: A ninth pass shifts eight zeros and ends with a falling `strobe_o` and no read-back, so all drive lines are low after every scan.
- R6: Every high time of `ser_clk_o` is exactly `div_i`+2 system clocks, and every low time is at least 2 system clocks.
- R7: `strobe_o` changes only at an edge after which `ser_clk_o` is low.
- R8: The key code is row*8+col: bits [5:3] hold the drive line and bits [2:0] the sense column. When several keys are down in one scan, the smallest code is taken.
- R9: `key_valid_o` pulses for one cycle at the end of a scan whose code equals the code of the directly preceding scan. The first scan after wake never emits, and neither does a scan whose code differs from the one before.
- R10: While the same key stays down over further scans, no further pulse is given.
- R11: If `wake_i` is low at the end of a scan, the scanner returns to idle and forgets the previous code, so a new press of the same key is reported again after two scans.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_i | input | 1 | Any-key detect, high when a key is down |
| div_i | input | DIV_W | Shift clock half period is `div_i`+2 system clocks |
| ser_clk_o | output | 1 | Shift clock shared by both registers |
| ser_dat_o | output | 1 | Serial data into the drive register |
| strobe_o | output | 1 | High: write phase; falling: latch drive and capture sense |
| ser_dat_i | input | 1 | Serial output of the sense register |
| key_code_o | output | CODE_W | Reported key code {row, col} |
| key_valid_o | output | 1 | One-cycle pulse when `key_code_o` is new |

## Verification
A pass or bit counter that is off by one shows up at the drive register as a line pattern that is not one-hot, or not zero at the ninth strobe fall, at the strobe edge of the first pass it affects. The same fault makes read-back samples land on the wrong column, which gives a wrong code one scan later. A broken debounce history shows up within two scans as a pulse after the first scan, a missing pulse, or a repeated pulse while a key is held. Timing faults in the divider are visible on the very first shift clock high time.

// File: rtl/kms_pkg.sv
package kms_pkg;

   typedef enum logic [1:0] {
      KS_IDLE  = 2'd0,
      KS_DRIVE = 2'd1,
      KS_LATCH = 2'd2,
      KS_SENSE = 2'd3
   } kms_phase_e;

   function automatic int kms_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/kms_halftick.sv
module kms_halftick #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             step_o
);
   localparam int CNT_W = DIV_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   // half period is div_i + 2 cycles, so the count runs 0 .. div_i + 1
   assign limit  = {1'b0, div_i} + CNT_W'(1);
   assign step_o = run_i && (cnt_q == limit);

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!run_i || step_o) cnt_q <= '0;
      else                       cnt_q <= cnt_q + CNT_W'(1);
   end

endmodule

// File: rtl/kms_sequencer.sv
module kms_sequencer
   import kms_pkg::*;
#(
   parameter int ROWS = 8,
   parameter int COLS = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wake_i,
   input  logic                     step_i,
   input  logic                     ser_dat_i,
   output logic                     run_o,
   output logic                     ser_clk_o,
   output logic                     ser_dat_o,
   output logic                     strobe_o,
   output logic                     row_done_o,
   output logic [$clog2(ROWS)-1:0]  row_idx_o,
   output logic [COLS-1:0]          sense_o,
   output logic                     scan_done_o,
   output logic                     scan_last_o
);
   localparam int RW = $clog2(ROWS);
   localparam int PW = $clog2(ROWS + 1);
   localparam int BW = $clog2(kms_max(ROWS, COLS));
   localparam logic [BW-1:0] WR_LAST   = BW'(ROWS - 1);
   localparam logic [BW-1:0] RD_LAST   = BW'(COLS - 1);
   localparam logic [PW-1:0] PASS_ZERO = PW'(ROWS);

   kms_phase_e      phase_q;
   logic [PW-1:0]   pass_q;
   logic [BW-1:0]   bit_q;
   logic            half_q;
   logic [COLS-1:0] sh_q;
   logic [RW-1:0]   row_q;
   logic            row_done_q, scan_done_q, scan_last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q     <= KS_IDLE;
         pass_q      <= '0;
         bit_q       <= '0;
         half_q      <= 1'b0;
         sh_q        <= '0;
         row_q       <= '0;
         row_done_q  <= 1'b0;
         scan_done_q <= 1'b0;
         scan_last_q <= 1'b0;
      end else begin
         row_done_q  <= 1'b0;
         scan_done_q <= 1'b0;
         unique case (phase_q)
            KS_IDLE: begin
               if (wake_i) begin
                  phase_q <= KS_DRIVE;
                  pass_q  <= '0;
                  bit_q   <= '0;
                  half_q  <= 1'b0;
               end
            end
            KS_DRIVE: begin
               if (step_i) begin
                  if (!half_q) half_q <= 1'b1;
                  else begin
                     half_q <= 1'b0;
                     if (bit_q == WR_LAST) begin
                        phase_q <= KS_LATCH;
                        bit_q   <= '0;
                     end else bit_q <= bit_q + BW'(1);
                  end
               end
            end
            KS_LATCH: begin
               if (step_i) begin
                  half_q <= 1'b0;
                  bit_q  <= '0;
                  if (pass_q == PASS_ZERO) begin
                     scan_done_q <= 1'b1;
                     scan_last_q <= !wake_i;
                     pass_q      <= '0;
                     phase_q     <= wake_i ? KS_DRIVE : KS_IDLE;
                  end else phase_q <= KS_SENSE;
               end
            end
            KS_SENSE: begin
               if (step_i) begin
                  if (!half_q) begin
                     sh_q   <= {sh_q[COLS-2:0], ser_dat_i};
                     half_q <= 1'b1;
                  end else begin
                     half_q <= 1'b0;
                     if (bit_q == RD_LAST) begin
                        row_done_q <= 1'b1;
                        row_q      <= pass_q[RW-1:0];
                        pass_q     <= pass_q + PW'(1);
                        bit_q      <= '0;
                        phase_q    <= KS_DRIVE;
                     end else bit_q <= bit_q + BW'(1);
                  end
               end
            end
            default: phase_q <= KS_IDLE;
         endcase
      end
   end

   assign run_o       = (phase_q != KS_IDLE);
   assign ser_clk_o   = half_q;
   assign strobe_o    = (phase_q == KS_DRIVE);
   // bit sent at step b belongs to line ROWS-1-b; the zero pass never matches
   assign ser_dat_o   = (phase_q == KS_DRIVE) &&
                        (int'(pass_q) + int'(bit_q) == ROWS - 1);
   assign row_done_o  = row_done_q;
   assign row_idx_o   = row_q;
   assign sense_o     = sh_q;
   assign scan_done_o = scan_done_q;
   assign scan_last_o = scan_last_q;

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == KS_IDLE) |-> (!ser_clk_o && !strobe_o && !ser_dat_o));

   assert_clk_min_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk_o != $past(ser_clk_o)) |-> ($past(ser_clk_o, 1) == $past(ser_clk_o, 2)));

   assert_strobe_clk_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_o != $past(strobe_o)) |-> !ser_clk_o);

endmodule

// File: rtl/kms_debounce.sv
module kms_debounce #(
   parameter int ROWS = 8,
   parameter int COLS = 8
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  row_done_i,
   input  logic [$clog2(ROWS)-1:0]               row_idx_i,
   input  logic [COLS-1:0]                       sense_i,
   input  logic                                  scan_done_i,
   input  logic                                  scan_last_i,
   output logic [$clog2(ROWS)+$clog2(COLS)-1:0]  key_code_o,
   output logic                                  key_valid_o
);
   localparam int CW     = $clog2(COLS);
   localparam int CODE_W = $clog2(ROWS) + CW;

   logic [CW-1:0]     low_col;
   logic [CODE_W-1:0] cand_q, prev_q;
   logic              cand_v_q, prev_v_q, rep_q;
   logic              same;

   // lowest pressed column wins inside a row
   always_comb begin
      low_col = '0;
      for (int i = COLS - 1; i >= 0; i--)
         if (sense_i[i]) low_col = CW'(i);
   end

   assign same = cand_v_q && prev_v_q && (cand_q == prev_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cand_q      <= '0;
         prev_q      <= '0;
         cand_v_q    <= 1'b0;
         prev_v_q    <= 1'b0;
         rep_q       <= 1'b0;
         key_code_o  <= '0;
         key_valid_o <= 1'b0;
      end else begin
         key_valid_o <= 1'b0;
         // rows arrive in ascending order: first hit is the smallest code
         if (row_done_i && !cand_v_q && (|sense_i)) begin
            cand_q   <= {row_idx_i, low_col};
            cand_v_q <= 1'b1;
         end
         if (scan_done_i) begin
            if (same && !rep_q) begin
               key_valid_o <= 1'b1;
               key_code_o  <= cand_q;
            end
            cand_v_q <= 1'b0;
            if (scan_last_i) begin
               prev_v_q <= 1'b0;
               rep_q    <= 1'b0;
            end else begin
               prev_q   <= cand_q;
               prev_v_q <= cand_v_q;
               rep_q    <= same;
            end
         end
      end
   end

   assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid_o |=> !key_valid_o);

endmodule

// File: rtl/kms_scanner.sv
module kms_scanner #(
   parameter int ROWS   = 8,
   parameter int COLS   = 8,
   parameter int DIV_W  = 4,
   localparam int CODE_W = $clog2(ROWS) + $clog2(COLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wake_i,
   input  logic [DIV_W-1:0]  div_i,
   output logic              ser_clk_o,
   output logic              ser_dat_o,
   output logic              strobe_o,
   input  logic              ser_dat_i,
   output logic [CODE_W-1:0] key_code_o,
   output logic              key_valid_o
);
   localparam int RW = $clog2(ROWS);

   generate
      if (ROWS < 2 || COLS < 2) begin : g_bad_dims
         $error("kms_scanner: ROWS and COLS must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("kms_scanner: DIV_W must be at least 1");
      end
   endgenerate

   logic            run, step;
   logic            row_done, scan_done, scan_last;
   logic [RW-1:0]   row_idx;
   logic [COLS-1:0] sense;

   kms_halftick #(.DIV_W(DIV_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run),
      .div_i  (div_i),
      .step_o (step)
   );

   kms_sequencer #(.ROWS(ROWS), .COLS(COLS)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .wake_i      (wake_i),
      .step_i      (step),
      .ser_dat_i   (ser_dat_i),
      .run_o       (run),
      .ser_clk_o   (ser_clk_o),
      .ser_dat_o   (ser_dat_o),
      .strobe_o    (strobe_o),
      .row_done_o  (row_done),
      .row_idx_o   (row_idx),
      .sense_o     (sense),
      .scan_done_o (scan_done),
      .scan_last_o (scan_last)
   );

   kms_debounce #(.ROWS(ROWS), .COLS(COLS)) u_deb (
      .clk         (clk),
      .rst_n       (rst_n),
      .row_done_i  (row_done),
      .row_idx_i   (row_idx),
      .sense_i     (sense),
      .scan_done_i (scan_done),
      .scan_last_i (scan_last),
      .key_code_o  (key_code_o),
      .key_valid_o (key_valid_o)
   );

   assert_read_data_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_o |-> !ser_dat_o);

endmodule

// File: tb/tb_kms_scanner.sv
module tb_kms_scanner;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] div = 4'd0;
   logic [63:0] keymap = '0;
   logic       wake;
   logic       ser_clk, ser_dat_o, strobe, ser_dat_i;
   logic [5:0] code;
   logic       valid;

   always #5 clk = ~clk;

   assign wake = |keymap;

   kms_scanner dut (
      .clk(clk), .rst_n(rst_n), .wake_i(wake), .div_i(div),
      .ser_clk_o(ser_clk), .ser_dat_o(ser_dat_o), .strobe_o(strobe),
      .ser_dat_i(ser_dat_i), .key_code_o(code), .key_valid_o(valid)
   );

   int checks = 0, bad = 0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int min_code(input logic [63:0] m);
      for (int i = 0; i < 64; i++) if (m[i]) return i;
      return -1;
   endfunction

   function automatic logic [7:0] sense_of(input logic [7:0] d, input logic [63:0] m);
      logic [7:0] s = '0;
      for (int c = 0; c < 8; c++)
         for (int r = 0; r < 8; r++)
            if (d[r] && m[r*8+c]) s[c] = 1'b1;
      return s;
   endfunction

   // external register models
   logic [7:0] dreg = '0, drv = '0, sreg = '0;
   int fall_idx = 0, scans = 0;
   assign ser_dat_i = sreg[7];

   always @(posedge ser_clk) if (rst_n) begin
      if (strobe) dreg <= {dreg[6:0], ser_dat_o};
      else        sreg <= {sreg[6:0], 1'b0};
   end

   always @(negedge strobe) if (rst_n) begin
      drv  = dreg;
      sreg <= sense_of(dreg, keymap);
      if (fall_idx < 8)
         check(drv == (8'd1 << fall_idx), "R3 one-hot drive pattern", drv, 1 << fall_idx);
      else
         check(drv == 8'd0, "R5 zero pass clears drive", drv, 0);
      if (fall_idx == 8) begin
         fall_idx = 0;
         scans++;
      end else fall_idx++;
   end

   // port monitor, sampled away from the active edge
   int seg = 0, sc_edges = 0, hi_err = 0, lo_err = 0, st_err = 0, dat_err = 0;
   int pulses = 0, last_code = -1;
   logic last_sc = 1'b0, last_st = 1'b0;
   always @(negedge clk) if (rst_n) begin
      if (ser_clk !== last_sc) begin
         if (last_sc) begin
            if (seg != int'(div) + 2) hi_err++;
         end else if (seg < 2) lo_err++;
         seg = 1;
         sc_edges++;
         last_sc = ser_clk;
      end else seg++;
      if (strobe !== last_st && ser_clk) st_err++;
      last_st = strobe;
      if (!strobe && ser_dat_o) dat_err++;
      if (valid) begin
         pulses++;
         last_code = int'(code);
      end
   end

   task automatic wait_scans(input int target);
      while (scans < target) @(negedge clk);
   endtask

   task automatic idle_check();
      int e0 = sc_edges;
      repeat (200) @(negedge clk);
      check(sc_edges == e0, "R1 no shift clock while idle", sc_edges - e0, 0);
      check(drv == 8'd0 && !strobe, "R5 drive lines low after scan", drv, 0);
   endtask

   task automatic press_cycle(input logic [63:0] m, input logic [3:0] dv);
      int base, s0, expc;
      @(negedge clk);
      div = dv;
      base = pulses; s0 = scans; expc = min_code(m);
      keymap = m;
      @(negedge clk);
      check(strobe == 1'b1, "R2 scan starts on wake", strobe, 1);
      wait_scans(s0 + 1);
      repeat (40) @(negedge clk);
      check(pulses == base, "R9 no report after first scan", pulses - base, 0);
      wait_scans(s0 + 2);
      repeat (2 * (int'(dv) + 2) + 10) @(negedge clk);
      check(pulses == base + 1, "R9 report after second scan", pulses - base, 1);
      check(last_code == expc, "R8 smallest code reported", last_code, expc);
      wait_scans(s0 + 3);
      keymap = '0;
      repeat (300) @(negedge clk);
      check(pulses == base + 1, "R10 no repeat while held", pulses - base, 1);
      idle_check();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         bad++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", scans, 0);
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] m;
      int base, s0;
      void'($urandom(32'd4711));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!ser_clk && !strobe && !ser_dat_o && !valid, "R1 reset state quiet",
            {ser_clk, strobe, ser_dat_o, valid}, 0);
      idle_check();

      // directed corners: code 0, code 63, slowest clock
      press_cycle(64'd1, 4'd0);
      press_cycle(64'd1 << 63, 4'd1);
      press_cycle((64'd1 << 63) | (64'd1 << 20), 4'd15);

      // same key twice: history cleared on return to idle
      press_cycle(64'd1 << 37, 4'd2);
      press_cycle(64'd1 << 37, 4'd2);
      check(last_code == 37, "R11 repeat press reported again", last_code, 37);

      // key changes between scans: only the stable one is reported
      @(negedge clk);
      div = 4'd1;
      base = pulses; s0 = scans;
      keymap = 64'd1 << 10;
      wait_scans(s0 + 1);
      keymap = 64'd1 << 45;
      wait_scans(s0 + 2);
      repeat (20) @(negedge clk);
      check(pulses == base, "R9 differing scans give no report", pulses - base, 0);
      wait_scans(s0 + 3);
      keymap = '0;
      repeat (300) @(negedge clk);
      check(pulses == base + 1, "R9 report after two agreeing scans", pulses - base, 1);
      check(last_code == 45, "R8 code of stable key", last_code, 45);
      idle_check();

      // constrained random key sets
      for (int i = 0; i < 6; i++) begin
         int n = 1 + int'($urandom % 3);
         m = '0;
         for (int k = 0; k < n; k++) m[$urandom % 64] = 1'b1;
         press_cycle(m, 4'($urandom % 4));
      end

      check(hi_err == 0, "R6 shift clock high time", hi_err, 0);
      check(lo_err == 0, "R6 shift clock low time", lo_err, 0);
      check(st_err == 0, "R7 strobe edge with clock low", st_err, 0);
      check(dat_err == 0, "R4 data low in read phase", dat_err, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule